// File: doc/BRIEF.md
# Character Display Command Executor

This block sits between a host byte link and a character-display scanner. Each byte arrives tagged as a command or as data. Commands are decoded by their highest set bit. They control:

- an address counter;
- the entry mode (step direction and automatic shift);
- the display, cursor and blink flags;
- a horizontal shift offset that applies to all three 16-character lines.

Data bytes are written to a 48-byte character memory or to the eight 5-bit rows of one user glyph. The selection depends on the address counter.

Clearing the display is a multi-cycle fill with the space code. During the fill, and during the start-up sequence, a busy flag is raised. Any byte that arrives while busy is dropped and recorded in a sticky overflow flag. The start-up sequence runs after the system reset. It also runs after a qualified external reset, meaning the external reset input was held low long enough. The scanner reads the character memory and the glyph rows through combinational read ports. It takes the flags and the shift offset straight from the outputs.

Top module: `chr_cmd_exec`

## Requirements
- R1: After reset `busy` is 1, `dispOn`/`cursorOn`/`blinkOn` are 0, `incDir` is 1 and `autoShift` is 0. Once `busy` falls, all 48 character bytes read 0x20, `curAddr` is 0 and `overflow` is 0.
- R2: A command byte of 0x00, or one whose highest set bit is bit 6 or bit 5, changes no state and does not raise `busy`.
- R3: Command 0b00001dcb loads `dispOn`=d, `cursorOn`=c and `blinkOn`=b.
- R4: Command 0b000001is loads `incDir`=i and `autoShift`=s.
- R5: Command 1aaaaaaa sets the address counter. If bit 6 is set, it selects glyph row aaa[2:0] and `curAddr` reads 0x40+row. Otherwise the address is reduced modulo 48, so 0x32 gives 0x02.
- R6: A data byte at a character address stores all 8 bits there. The counter then steps +1 when `incDir`=1 and −1 otherwise, wrapping 0x2F→0x00 and 0x00→0x2F.
- R7: A data byte at a glyph address stores its low 5 bits in that row. The counter wraps within 0x40–0x47, and `shiftOfs` never changes.
- R8: With `autoShift`=1, a character write also moves the offset: +1 (left) when `incDir`=1 and −1 (right) when `incDir`=0, modulo 16.
- R9: Command 0b0001sr·· moves the cursor when s=0 (r=1 gives +1, r=0 gives −1, with the R6/R7 wrap rules). It moves the offset when s=1 (r=0 gives +1, r=1 gives −1, modulo 16), and in that case the counter is unchanged.
- R10: Command 0b0000001· sets the counter and the offset to 0 and leaves memory unchanged.
- R11: Command 0x01 fills all 48 character bytes with 0x20 and sets the counter to 0, the offset to 0 and `incDir` to 1. It leaves `autoShift`, the flags and the glyph rows unchanged. `busy` is high for exactly 48 cycles, starting in the cycle after the command is accepted.
- R12: Any byte arriving while `busy` is 1 is dropped without effect and sets `overflow`. `overflow` stays set until the next start-up sequence.
- R13: Holding `extResetN` low for at least 8 cycles and then releasing it restarts the start-up sequence. This clears the flags and `overflow` and refills with spaces. A shorter low pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| extResetN | input | 1 | Synchronous external reset request, active low, qualified by width |
| inValid | input | 1 | Byte strobe, one cycle per byte |
| inIsData | input | 1 | 1 = data byte, 0 = command byte |
| inByte | input | 8 | Byte value |
| rdAddr | input | 6 | Scanner read address for the character memory |
| rdData | output | 8 | Character byte at rdAddr (0 beyond 47) |
| glyphRowAddr | input | 3 | Scanner read row of the user glyph |
| glyphRowData | output | 5 | Glyph row bits |
| busy | output | 1 | Start-up or clear in progress |
| overflow | output | 1 | Sticky: a byte was dropped while busy |
| curAddr | output | 7 | Address counter (cursor position) |
| shiftOfs | output | 4 | Horizontal display shift offset |
| dispOn | output | 1 | Display enable flag |
| cursorOn | output | 1 | Cursor enable flag |
| blinkOn | output | 1 | Blink enable flag |
| incDir | output | 1 | Entry step direction, 1 = increment |
| autoShift | output | 1 | Entry automatic display shift |

## Verification
The main function is the command decoder and the address stepping. Each command byte is exercised with neighbouring codes, so a decoder that keys on the wrong bit produces a visibly different counter, flag or offset.

Writes are driven across both wrap points of the character range, across the glyph row range, and with automatic shift on and off in both directions. This separates the shared counter step from the shift logic. Clears and resets are issued after the memory, the offset and the entry mode hold non-default values, which separates what a clear restores from what it must leave alone. Bytes sent during a fill, and external reset pulses just under and over the qualifying width, separate a real drop and restart from an accidental one.

// File: rtl/chr_exec_pkg.sv
`timescale 1ns/1ps
package chr_exec_pkg;
  localparam int CMD_ADDR_W = 7;
  localparam int FILL_IDX_W = 6;

  typedef enum logic [1:0] {ST_WAIT, ST_FILL, ST_IDLE} ctrl_state_e;

  typedef struct packed {
    logic                  initFlags;
    logic                  clrStart;
    logic                  fillWr;
    logic [FILL_IDX_W-1:0] fillIdx;
    logic                  homeAc;
    logic                  setAddr;
    logic [CMD_ADDR_W-1:0] addr;
    logic                  dataWr;
    logic [7:0]            data;
    logic                  setEntry;
    logic [1:0]            entryVal;
    logic                  setCtl;
    logic [2:0]            ctlVal;
    logic                  curMove;
    logic                  dispMove;
    logic                  right;
  } dp_strobe_t;
endpackage

// File: rtl/chr_exec_ctrl.sv
`timescale 1ns/1ps
module chr_exec_ctrl
  import chr_exec_pkg::*;
#(
  parameter int DISP_DEPTH = 48,
  parameter int INIT_WAIT  = 20,
  parameter int RST_MIN    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extResetN,
  input  logic       inValid,
  input  logic       inIsData,
  input  logic [7:0] inByte,
  output dp_strobe_t strobe,
  output logic       busy,
  output logic       overflow
);
  localparam int WW = $clog2(INIT_WAIT + 1);
  localparam int LW = $clog2(RST_MIN + 1);
  localparam logic [WW-1:0] WAIT_LAST = WW'(INIT_WAIT - 1);
  localparam logic [LW-1:0] LOW_FULL  = LW'(RST_MIN);
  localparam logic [FILL_IDX_W-1:0] FILL_LAST = FILL_IDX_W'(DISP_DEPTH - 1);

  ctrl_state_e           state;
  logic [WW-1:0]         waitCnt;
  logic [FILL_IDX_W-1:0] fillIdx;
  logic [LW-1:0]         lowCnt;
  logic                  armed;
  logic                  extRelease;

  assign armed      = (lowCnt == LOW_FULL);
  assign extRelease = extResetN && armed;
  assign busy       = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_WAIT: if (waitCnt == WAIT_LAST) strobe.clrStart = 1'b1;
      ST_FILL: begin
        strobe.fillWr  = 1'b1;
        strobe.fillIdx = fillIdx;
      end
      default: if (inValid) begin
        if (inIsData) begin
          strobe.dataWr = 1'b1;
          strobe.data   = inByte;
        end else if (inByte[7]) begin
          strobe.setAddr = 1'b1;
          strobe.addr    = inByte[6:0];
        end else if (inByte[6] || inByte[5]) begin
          strobe = '0;
        end else if (inByte[4]) begin
          strobe.dispMove = inByte[3];
          strobe.curMove  = !inByte[3];
          strobe.right    = inByte[2];
        end else if (inByte[3]) begin
          strobe.setCtl = 1'b1;
          strobe.ctlVal = inByte[2:0];
        end else if (inByte[2]) begin
          strobe.setEntry = 1'b1;
          strobe.entryVal = inByte[1:0];
        end else if (inByte[1]) begin
          strobe.homeAc = 1'b1;
        end else if (inByte[0]) begin
          strobe.clrStart = 1'b1;
        end
      end
    endcase
    if (extRelease) begin
      strobe           = '0;
      strobe.initFlags = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_WAIT;
      waitCnt  <= '0;
      fillIdx  <= '0;
      overflow <= 1'b0;
      lowCnt   <= '0;
    end else begin
      if (!extResetN) lowCnt <= armed ? lowCnt : lowCnt + 1'b1;
      else            lowCnt <= '0;

      if (extRelease) begin
        state    <= ST_WAIT;
        waitCnt  <= '0;
        fillIdx  <= '0;
        overflow <= 1'b0;
      end else begin
        if (inValid && busy) overflow <= 1'b1;
        unique case (state)
          ST_WAIT: begin
            if (waitCnt == WAIT_LAST) begin
              state   <= ST_FILL;
              fillIdx <= '0;
            end else begin
              waitCnt <= waitCnt + 1'b1;
            end
          end
          ST_FILL: begin
            if (fillIdx == FILL_LAST) state <= ST_IDLE;
            else                      fillIdx <= fillIdx + 1'b1;
          end
          default: begin
            if (strobe.clrStart) begin
              state   <= ST_FILL;
              fillIdx <= '0;
            end
          end
        endcase
      end
    end
  end

  // R12: a byte seen while busy leaves the overflow flag raised
  a_r12_drop_sets_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && busy && !extRelease) |=> overflow);

  // R12: overflow only falls through a restart
  a_r12_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !extRelease) |=> overflow);

  // R11: the fill walks one location per cycle
  a_r11_fill_advances: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL && fillIdx != FILL_LAST && !extRelease)
      |=> (state == ST_FILL && fillIdx == $past(fillIdx) + 1'b1));

  // R13: a qualified release restarts and clears overflow
  a_r13_release_restarts: assert property (@(posedge clk) disable iff (!rstN)
    extRelease |=> (state == ST_WAIT && !overflow && busy));
endmodule

// File: rtl/chr_exec_dp.sv
`timescale 1ns/1ps
module chr_exec_dp
  import chr_exec_pkg::*;
#(
  parameter int LINE_CHARS = 16,
  parameter int DISP_LINES = 3,
  parameter int GLYPH_ROWS = 8,
  parameter int GLYPH_W    = 5
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  dp_strobe_t                             strobe,
  input  logic [$clog2(LINE_CHARS*DISP_LINES)-1:0] rdAddr,
  output logic [7:0]                             rdData,
  input  logic [$clog2(GLYPH_ROWS)-1:0]          glyphRowAddr,
  output logic [GLYPH_W-1:0]                     glyphRowData,
  output logic [CMD_ADDR_W-1:0]                  curAddr,
  output logic [$clog2(LINE_CHARS)-1:0]          shiftOfs,
  output logic                                   dispOn,
  output logic                                   cursorOn,
  output logic                                   blinkOn,
  output logic                                   incDir,
  output logic                                   autoShift
);
  localparam int DISP_DEPTH = LINE_CHARS * DISP_LINES;
  localparam int IDX_W      = $clog2(DISP_DEPTH);
  localparam int OFS_W      = $clog2(LINE_CHARS);
  localparam int ROW_W      = $clog2(GLYPH_ROWS);
  localparam logic [CMD_ADDR_W-1:0] GLYPH_BASE = 7'h40;
  localparam logic [CMD_ADDR_W-1:0] DISP_LAST  = CMD_ADDR_W'(DISP_DEPTH - 1);
  localparam logic [7:0] SPACE_CODE = 8'h20;

  logic [7:0]           dispMem  [DISP_DEPTH];
  logic [GLYPH_W-1:0]   glyphMem [GLYPH_ROWS];
  logic [CMD_ADDR_W-1:0] ac;
  logic [OFS_W-1:0]     ofs;
  logic                 inGlyph;

  assign inGlyph = ac[6];

  function automatic logic [CMD_ADDR_W-1:0] stepAc(input logic [CMD_ADDR_W-1:0] a,
                                                   input logic up);
    logic [ROW_W-1:0] r;
    if (a[6]) begin
      r = a[ROW_W-1:0];
      r = up ? r + 1'b1 : r - 1'b1;
      stepAc = GLYPH_BASE | CMD_ADDR_W'(r);
    end else if (up) begin
      stepAc = (a == DISP_LAST) ? '0 : a + 1'b1;
    end else begin
      stepAc = (a == '0) ? DISP_LAST : a - 1'b1;
    end
  endfunction

  function automatic logic [CMD_ADDR_W-1:0] normAddr(input logic [CMD_ADDR_W-1:0] a);
    if (a[6]) normAddr = GLYPH_BASE | CMD_ADDR_W'(a[ROW_W-1:0]);
    else      normAddr = CMD_ADDR_W'(a % CMD_ADDR_W'(DISP_DEPTH));
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ac        <= '0;
      ofs       <= '0;
      dispOn    <= 1'b0;
      cursorOn  <= 1'b0;
      blinkOn   <= 1'b0;
      incDir    <= 1'b1;
      autoShift <= 1'b0;
    end else begin
      if (strobe.initFlags) begin
        dispOn    <= 1'b0;
        cursorOn  <= 1'b0;
        blinkOn   <= 1'b0;
        incDir    <= 1'b1;
        autoShift <= 1'b0;
      end
      if (strobe.clrStart) begin
        ac     <= '0;
        ofs    <= '0;
        incDir <= 1'b1;
      end
      if (strobe.homeAc) begin
        ac  <= '0;
        ofs <= '0;
      end
      if (strobe.setAddr) ac <= normAddr(strobe.addr);
      if (strobe.setEntry) begin
        incDir    <= strobe.entryVal[1];
        autoShift <= strobe.entryVal[0];
      end
      if (strobe.setCtl) {dispOn, cursorOn, blinkOn} <= strobe.ctlVal;
      if (strobe.curMove) ac <= stepAc(ac, strobe.right);
      if (strobe.dispMove) ofs <= strobe.right ? ofs - 1'b1 : ofs + 1'b1;
      if (strobe.dataWr) begin
        ac <= stepAc(ac, incDir);
        if (!inGlyph && autoShift) ofs <= incDir ? ofs + 1'b1 : ofs - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWr)
      dispMem[strobe.fillIdx[IDX_W-1:0]] <= SPACE_CODE;
    else if (strobe.dataWr && !inGlyph)
      dispMem[ac[IDX_W-1:0]] <= strobe.data;
    if (strobe.dataWr && inGlyph)
      glyphMem[ac[ROW_W-1:0]] <= strobe.data[GLYPH_W-1:0];
  end

  assign rdData       = (32'(rdAddr) < DISP_DEPTH) ? dispMem[rdAddr] : 8'h00;
  assign glyphRowData = glyphMem[glyphRowAddr];
  assign curAddr      = ac;
  assign shiftOfs     = ofs;

  // R5: the counter only ever holds a character or glyph address
  a_r5_addr_legal: assert property (@(posedge clk) disable iff (!rstN)
    (ac <= DISP_LAST) || (ac >= GLYPH_BASE && ac < GLYPH_BASE + CMD_ADDR_W'(GLYPH_ROWS)));

  // R9: a display shift leaves the counter alone
  a_r9_dispmove_keeps_ac: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dispMove |=> $stable(ac));

  // R7: glyph writes never move the offset
  a_r7_glyph_no_shift: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataWr && inGlyph) |=> $stable(ofs));

  // R10: home zeroes counter and offset
  a_r10_home: assert property (@(posedge clk) disable iff (!rstN)
    strobe.homeAc |=> (ac == '0 && ofs == '0));

  // R6: a character write lands at the old counter value
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataWr && !inGlyph)
      |=> dispMem[$past(ac[IDX_W-1:0])] == $past(strobe.data));
endmodule

// File: rtl/chr_cmd_exec.sv
`timescale 1ns/1ps
module chr_cmd_exec
  import chr_exec_pkg::*;
#(
  parameter int LINE_CHARS = 16,
  parameter int DISP_LINES = 3,
  parameter int GLYPH_ROWS = 8,
  parameter int GLYPH_W    = 5,
  parameter int INIT_WAIT  = 20,
  parameter int RST_MIN    = 8
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     extResetN,
  input  logic                                     inValid,
  input  logic                                     inIsData,
  input  logic [7:0]                               inByte,
  input  logic [$clog2(LINE_CHARS*DISP_LINES)-1:0] rdAddr,
  output logic [7:0]                               rdData,
  input  logic [$clog2(GLYPH_ROWS)-1:0]            glyphRowAddr,
  output logic [GLYPH_W-1:0]                       glyphRowData,
  output logic                                     busy,
  output logic                                     overflow,
  output logic [6:0]                               curAddr,
  output logic [$clog2(LINE_CHARS)-1:0]            shiftOfs,
  output logic                                     dispOn,
  output logic                                     cursorOn,
  output logic                                     blinkOn,
  output logic                                     incDir,
  output logic                                     autoShift
);
  localparam int DISP_DEPTH = LINE_CHARS * DISP_LINES;

  dp_strobe_t strobe;

  chr_exec_ctrl #(
    .DISP_DEPTH(DISP_DEPTH),
    .INIT_WAIT (INIT_WAIT),
    .RST_MIN   (RST_MIN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .extResetN(extResetN),
    .inValid  (inValid),
    .inIsData (inIsData),
    .inByte   (inByte),
    .strobe   (strobe),
    .busy     (busy),
    .overflow (overflow)
  );

  chr_exec_dp #(
    .LINE_CHARS(LINE_CHARS),
    .DISP_LINES(DISP_LINES),
    .GLYPH_ROWS(GLYPH_ROWS),
    .GLYPH_W   (GLYPH_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .glyphRowAddr(glyphRowAddr),
    .glyphRowData(glyphRowData),
    .curAddr     (curAddr),
    .shiftOfs    (shiftOfs),
    .dispOn      (dispOn),
    .cursorOn    (cursorOn),
    .blinkOn     (blinkOn),
    .incDir      (incDir),
    .autoShift   (autoShift)
  );
endmodule

// File: tb/chr_cmd_exec_tb.sv
`timescale 1ns/1ps
module chr_cmd_exec_tb;
  localparam int K_BUSY = 0, K_AC = 1, K_OFS = 2, K_FLAGS = 3, K_ENTRY = 4,
                 K_OVF = 5, K_MEM = 6, K_GLYPH = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extResetN = 1'b1;
  logic inValid = 1'b0;
  logic inIsData = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic [5:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [2:0] glyphRowAddr = '0;
  logic [4:0] glyphRowData;
  logic busy, overflow, dispOn, cursorOn, blinkOn, incDir, autoShift;
  logic [6:0] curAddr;
  logic [3:0] shiftOfs;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  chr_cmd_exec u_dut (
    .clk(clk), .rstN(rstN), .extResetN(extResetN), .inValid(inValid),
    .inIsData(inIsData), .inByte(inByte), .rdAddr(rdAddr), .rdData(rdData),
    .glyphRowAddr(glyphRowAddr), .glyphRowData(glyphRowData), .busy(busy),
    .overflow(overflow), .curAddr(curAddr), .shiftOfs(shiftOfs),
    .dispOn(dispOn), .cursorOn(cursorOn), .blinkOn(blinkOn),
    .incDir(incDir), .autoShift(autoShift)
  );

  typedef struct {
    string req;
    int    kind;
    int    idx;
    int    exp;
  } exp_t;

  exp_t q[$];
  bit   reqFlag = 1'b0;

  task automatic chk(input string req, input int kind, input int idx, input int exp);
    exp_t e;
    e.req = req; e.kind = kind; e.idx = idx; e.exp = exp;
    q.push_back(e);
  endtask

  task automatic drain();
    reqFlag = 1'b1;
    wait (reqFlag == 1'b0);
  endtask

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      wait (reqFlag == 1'b1);
      while (q.size() > 0) begin
        exp_t e;
        int act;
        e = q.pop_front();
        #1;
        case (e.kind)
          K_BUSY:  act = int'(busy);
          K_AC:    act = int'(curAddr);
          K_OFS:   act = int'(shiftOfs);
          K_FLAGS: act = int'({dispOn, cursorOn, blinkOn});
          K_ENTRY: act = int'({incDir, autoShift});
          K_OVF:   act = int'(overflow);
          K_MEM:   begin rdAddr = 6'(e.idx); #1; act = int'(rdData); end
          default: begin glyphRowAddr = 3'(e.idx); #1; act = int'(glyphRowData); end
        endcase
        checks++;
        if (act != e.exp) begin
          errors++;
          $display("FAIL %s kind=%0d idx=%0d actual=0x%0h expected=0x%0h",
                   e.req, e.kind, e.idx, act, e.exp);
        end
      end
      reqFlag = 1'b0;
    end
  end

  task automatic sendByte(input bit isData, input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1; inIsData = isData; inByte = b;
    @(negedge clk);
    inValid = 1'b0; inIsData = 1'b0; inByte = 8'h00;
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 400 && busy; n++) @(negedge clk);
  endtask

  task automatic chkAllSpace(input string req);
    for (int a = 0; a < 48; a++) chk(req, K_MEM, a, 8'h20);
    drain();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 start-up state
    chk("R1", K_BUSY, 0, 1); chk("R1", K_FLAGS, 0, 0); chk("R1", K_ENTRY, 0, 2'b10);
    drain();
    waitIdle();
    chk("R1", K_BUSY, 0, 0); chk("R1", K_AC, 0, 0); chk("R1", K_OVF, 0, 0);
    drain();
    chkAllSpace("R1");

    // R3 on/off
    sendByte(0, 8'h0F); chk("R3", K_FLAGS, 0, 3'b111); drain();
    sendByte(0, 8'h0A); chk("R3", K_FLAGS, 0, 3'b010); drain();

    // R4 entry
    sendByte(0, 8'h05); chk("R4", K_ENTRY, 0, 2'b01); drain();
    sendByte(0, 8'h06); chk("R4", K_ENTRY, 0, 2'b10); drain();

    // R5 address map
    sendByte(0, 8'h85); chk("R5", K_AC, 0, 8'h05); drain();
    sendByte(0, 8'hC3); chk("R5", K_AC, 0, 8'h43); drain();
    sendByte(0, 8'hB2); chk("R5", K_AC, 0, 8'h02); drain();
    sendByte(0, 8'hFF); chk("R5", K_AC, 0, 8'h47); drain();

    // R6 character writes with wrap both ways
    sendByte(0, 8'hAE);
    sendByte(1, 8'h41); sendByte(1, 8'h42); sendByte(1, 8'h43);
    chk("R6", K_MEM, 8'h2E, 8'h41); chk("R6", K_MEM, 8'h2F, 8'h42);
    chk("R6", K_MEM, 8'h00, 8'h43); chk("R6", K_AC, 0, 8'h01); chk("R6", K_OFS, 0, 0);
    drain();
    sendByte(0, 8'h04); sendByte(0, 8'h80); sendByte(1, 8'h55);
    chk("R6", K_MEM, 0, 8'h55); chk("R6", K_AC, 0, 8'h2F); drain();

    // R7 glyph rows, wrap, no shift even with autoShift
    sendByte(0, 8'h07); sendByte(0, 8'hC6);
    sendByte(1, 8'hFF); chk("R7", K_GLYPH, 6, 5'h1F); chk("R7", K_AC, 0, 8'h47); drain();
    sendByte(1, 8'h0A);
    chk("R7", K_GLYPH, 7, 5'h0A); chk("R7", K_AC, 0, 8'h40); chk("R7", K_OFS, 0, 0); drain();
    sendByte(0, 8'hC3); sendByte(1, 8'h15); chk("R7", K_GLYPH, 3, 5'h15); drain();

    // R8 automatic shift
    sendByte(0, 8'h90); sendByte(1, 8'h61);
    chk("R8", K_MEM, 8'h10, 8'h61); chk("R8", K_AC, 0, 8'h11); chk("R8", K_OFS, 0, 1); drain();
    sendByte(0, 8'h05); sendByte(1, 8'h62);
    chk("R8", K_MEM, 8'h11, 8'h62); chk("R8", K_AC, 0, 8'h10); chk("R8", K_OFS, 0, 0); drain();
    sendByte(1, 8'h63);
    chk("R8", K_AC, 0, 8'h0F); chk("R8", K_OFS, 0, 15); drain();

    // R10 home keeps memory
    sendByte(0, 8'h02);
    chk("R10", K_AC, 0, 0); chk("R10", K_OFS, 0, 0); chk("R10", K_MEM, 8'h10, 8'h63); drain();

    // R9 cursor and display shifts
    sendByte(0, 8'h14); chk("R9", K_AC, 0, 1); drain();
    sendByte(0, 8'h10); chk("R9", K_AC, 0, 0); drain();
    sendByte(0, 8'h10); chk("R9", K_AC, 0, 8'h2F); drain();
    sendByte(0, 8'h18); chk("R9", K_OFS, 0, 1); chk("R9", K_AC, 0, 8'h2F); drain();
    sendByte(0, 8'h1C); chk("R9", K_OFS, 0, 0); drain();
    sendByte(0, 8'h1C); chk("R9", K_OFS, 0, 15); chk("R9", K_AC, 0, 8'h2F); drain();
    sendByte(0, 8'hC7); sendByte(0, 8'h14); chk("R9", K_AC, 0, 8'h40); drain();
    sendByte(0, 8'h02);
    chk("R10", K_AC, 0, 0); chk("R10", K_OFS, 0, 0); chk("R10", K_GLYPH, 6, 5'h1F); drain();

    // R2 ignored codes
    sendByte(0, 8'h00); sendByte(0, 8'h20); sendByte(0, 8'h40);
    sendByte(0, 8'h7F); sendByte(0, 8'h3F);
    chk("R2", K_BUSY, 0, 0); chk("R2", K_AC, 0, 0); chk("R2", K_OFS, 0, 0);
    chk("R2", K_FLAGS, 0, 3'b010); chk("R2", K_ENTRY, 0, 2'b01);
    chk("R2", K_MEM, 8'h10, 8'h63);
    drain();

    // R11 clear
    sendByte(0, 8'h18); sendByte(0, 8'h85);
    sendByte(0, 8'h01);
    n = 0;
    while (busy && n < 200) begin n++; @(negedge clk); end
    checks++;
    if (n != 48) begin
      errors++;
      $display("FAIL R11 busy cycles actual=%0d expected=48", n);
    end
    chk("R11", K_AC, 0, 0); chk("R11", K_OFS, 0, 0); chk("R11", K_ENTRY, 0, 2'b11);
    chk("R11", K_FLAGS, 0, 3'b010); chk("R11", K_GLYPH, 3, 5'h15); chk("R11", K_GLYPH, 6, 5'h1F);
    drain();
    chkAllSpace("R11");

    // R12 drop while busy
    sendByte(0, 8'h0F);
    chk("R12", K_OVF, 0, 0); drain();
    sendByte(0, 8'h01);
    sendByte(0, 8'h08);
    waitIdle();
    chk("R12", K_FLAGS, 0, 3'b111); chk("R12", K_OVF, 0, 1); drain();
    sendByte(0, 8'h06);
    chk("R12", K_OVF, 0, 1); chk("R12", K_ENTRY, 0, 2'b10); drain();

    // R13 short pulse ignored
    sendByte(1, 8'h41);
    @(negedge clk); extResetN = 1'b0;
    repeat (6) @(negedge clk);
    extResetN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13", K_BUSY, 0, 0); chk("R13", K_FLAGS, 0, 3'b111); chk("R13", K_OVF, 0, 1);
    chk("R13", K_MEM, 0, 8'h41);
    drain();

    // R13 qualified pulse restarts
    extResetN = 1'b0;
    repeat (10) @(negedge clk);
    extResetN = 1'b1;
    @(negedge clk);
    chk("R13", K_BUSY, 0, 1); chk("R13", K_FLAGS, 0, 0); chk("R13", K_ENTRY, 0, 2'b10);
    chk("R13", K_OVF, 0, 0);
    drain();
    waitIdle();
    chk("R13", K_BUSY, 0, 0); chk("R13", K_AC, 0, 0); chk("R13", K_GLYPH, 6, 5'h1F);
    drain();
    chkAllSpace("R13");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule